// File: doc/BRIEF.md
# Four-Phase Handshake Clock-Domain Bridge

This block carries one data word at a time from a source clock domain to a destination clock domain. The two clocks have no known phase or frequency relation. On the source side, upstream logic offers words through a valid/ready pair. The word goes into a holding register, and a request line is raised toward the destination.

The destination side brings the request through a flip-flop synchronizer. On its rising edge, the destination copies the held word and presents it downstream through a second valid/ready pair. Only after downstream takes the word does the destination raise an acknowledge, which is synchronized back into the source domain.

Each word then completes a return-to-zero exchange: the request falls, the acknowledge falls, and the source may accept its next word. This costs four line transitions per word. The source holding register never changes while a word is in flight, so no data bit can be caught mid-change.

Top module: `hs_cdc_bridge`

## Requirements
- R1: While either reset is low and after release with no upstream traffic, `dn_valid` is 0 and `up_ready` is 1. Each domain has its own asynchronous active-low reset that clears its request or acknowledge line and its valid output.
- R2: `up_ready` is 1 only while the source side is idle. The cycle after a transfer (`up_valid` and `up_ready` both 1 at a `clk_src` edge), `up_ready` is 0.
- R3: Each word accepted upstream appears on `dn_data` with `dn_valid` 1, exactly once and in acceptance order, with all `DATA_W` bits unchanged.
- R4: The source holding register keeps its value from the edge that raises the request until the synchronized acknowledge has fallen again.
- R5: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` stays 1 and `dn_data` stays constant. The cycle after `dn_valid` and `dn_ready` are both 1, `dn_valid` is 0.
- R6: The acknowledge rises only after downstream has taken the word. While downstream stalls, `up_ready` stays 0.
- R7: The request falls only after the synchronized acknowledge is seen high. The acknowledge falls only after the synchronized request is seen low.
- R8: At most one word is in flight. A second word offered while the first is undelivered is not taken, and it is delivered after the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source-domain clock |
| rst_src_n | input | 1 | Source-domain asynchronous reset, active low |
| up_valid | input | 1 | Upstream offers a word |
| up_ready | output | 1 | Source side can take a word |
| up_data | input | DATA_W | Upstream word |
| clk_dst | input | 1 | Destination-domain clock |
| rst_dst_n | input | 1 | Destination-domain asynchronous reset, active low |
| dn_valid | output | 1 | Word presented downstream |
| dn_ready | input | 1 | Downstream takes the word |
| dn_data | output | DATA_W | Delivered word |

## Verification
The bench holds downstream stalls of zero to many cycles. A bridge that raised its acknowledge early would let `up_ready` return during the stall, or drop the presented word. It also keeps `up_valid` high with a new word while the previous one is still in flight. A sender that reloaded its register while busy would lose or corrupt that word, or deliver it twice. All-zero and all-one words test for stuck data bits. The two clocks run at unrelated periods, so a synchronizer fault or a wrong edge detect shows up as a missing or repeated delivery.

// File: rtl/hs_bridge_pkg.sv
`timescale 1ns/1ps
package hs_bridge_pkg;

  typedef enum logic [1:0] {
    SND_IDLE       = 2'd0,
    SND_WAIT_ACKHI = 2'd1,
    SND_WAIT_ACKLO = 2'd2
  } snd_state_e;

  typedef enum logic [1:0] {
    RCV_IDLE    = 2'd0,
    RCV_PRESENT = 2'd1,
    RCV_ACKHI   = 2'd2
  } rcv_state_e;

  // Source side may take a word only when fully quiet.
  function automatic logic snd_can_accept(snd_state_e st, logic req, logic ack_s);
    return (st == SND_IDLE) && !req && !ack_s;
  endfunction

  function automatic logic edge_rise(logic cur, logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/hs_sync.sv
`timescale 1ns/1ps
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_send.sv
`timescale 1ns/1ps
module hs_send
  import hs_bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              ack_sync,
  output logic              req,
  output logic [DATA_W-1:0] hold_data
);
  snd_state_e        state;
  logic              req_q;
  logic [DATA_W-1:0] data_q;
  logic              take;
  logic              busy;

  assign up_ready  = snd_can_accept(state, req_q, ack_sync);
  assign take      = up_valid & up_ready;
  assign busy      = (state != SND_IDLE);
  assign req       = req_q;
  assign hold_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SND_IDLE;
      req_q  <= 1'b0;
      data_q <= '0;
    end else begin
      case (state)
        SND_IDLE: begin
          if (take) begin
            data_q <= up_data;
            req_q  <= 1'b1;
            state  <= SND_WAIT_ACKHI;
          end
        end
        SND_WAIT_ACKHI: begin
          if (ack_sync) begin
            req_q <= 1'b0;
            state <= SND_WAIT_ACKLO;
          end
        end
        SND_WAIT_ACKLO: begin
          if (!ack_sync) state <= SND_IDLE;
        end
        default: state <= SND_IDLE;
      endcase
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !up_ready);
  assert_req_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(take));
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(data_q));
  assert_req_fall_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(ack_sync));
endmodule

// File: rtl/hs_recv.sv
`timescale 1ns/1ps
module hs_recv
  import hs_bridge_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_sync,
  input  logic [DATA_W-1:0] src_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              ack
);
  rcv_state_e        state;
  logic              req_prev;
  logic              req_rise;
  logic              dn_fire;
  logic              valid_q;
  logic              ack_q;
  logic [DATA_W-1:0] data_q;

  assign req_rise = edge_rise(req_sync, req_prev);
  assign dn_fire  = valid_q & dn_ready;
  assign dn_valid = valid_q;
  assign dn_data  = data_q;
  assign ack      = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RCV_IDLE;
      req_prev <= 1'b0;
      valid_q  <= 1'b0;
      ack_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      req_prev <= req_sync;
      case (state)
        RCV_IDLE: begin
          if (req_rise) begin
            data_q  <= src_data;
            valid_q <= 1'b1;
            state   <= RCV_PRESENT;
          end
        end
        RCV_PRESENT: begin
          if (dn_fire) begin
            valid_q <= 1'b0;
            ack_q   <= 1'b1;
            state   <= RCV_ACKHI;
          end
        end
        RCV_ACKHI: begin
          if (!req_sync) begin
            ack_q <= 1'b0;
            state <= RCV_IDLE;
          end
        end
        default: state <= RCV_IDLE;
      endcase
    end
  end

  assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !dn_ready) |=> (valid_q && $stable(data_q)));
  assert_valid_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_fire |=> !valid_q);
  assert_ack_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(dn_fire));
  assert_ack_fall_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> !$past(req_sync));
  assert_no_valid_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && ack_q));
endmodule

// File: rtl/hs_cdc_bridge.sv
`timescale 1ns/1ps
module hs_cdc_bridge #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_src,
  input  logic              rst_src_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              clk_dst,
  input  logic              rst_dst_n,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              req_src;
  logic              ack_dst;
  logic              req_in_dst;
  logic              ack_in_src;
  logic [DATA_W-1:0] hold_data;

  hs_send #(.DATA_W(DATA_W)) u_send (
    .clk       (clk_src),
    .rst_n     (rst_src_n),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .up_data   (up_data),
    .ack_sync  (ack_in_src),
    .req       (req_src),
    .hold_data (hold_data)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk_dst),
    .rst_n (rst_dst_n),
    .d     (req_src),
    .q     (req_in_dst)
  );

  hs_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk_src),
    .rst_n (rst_src_n),
    .d     (ack_dst),
    .q     (ack_in_src)
  );

  hs_recv #(.DATA_W(DATA_W)) u_recv (
    .clk      (clk_dst),
    .rst_n    (rst_dst_n),
    .req_sync (req_in_dst),
    .src_data (hold_data),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_data  (dn_data),
    .ack      (ack_dst)
  );
endmodule

// File: tb/hs_cdc_bridge_tb.sv
`timescale 1ns/1ps
module hs_cdc_bridge_tb;
  localparam int DW = 16;
  localparam int NV = 8;

  // vector: {word, downstream stall cycles}
  localparam logic [DW+3:0] VEC [NV] = '{
    {16'hA5C3, 4'd0}, {16'h0000, 4'd3}, {16'hFFFF, 4'd0}, {16'h1234, 4'd9},
    {16'h8001, 4'd1}, {16'h7FFE, 4'd15}, {16'h5555, 4'd2}, {16'hAAAA, 4'd0}
  };

  logic clk_src = 1'b0, clk_dst = 1'b0;
  logic rst_src_n = 1'b0, rst_dst_n = 1'b0;
  logic up_valid = 1'b0, dn_ready = 1'b0;
  logic [DW-1:0] up_data = '0;
  logic up_ready, dn_valid;
  logic [DW-1:0] dn_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_src = ~clk_src;
  always #5.5 clk_dst = ~clk_dst;

  hs_cdc_bridge #(.DATA_W(DW)) u_dut (
    .clk_src(clk_src), .rst_src_n(rst_src_n), .up_valid(up_valid),
    .up_ready(up_ready), .up_data(up_data), .clk_dst(clk_dst),
    .rst_dst_n(rst_dst_n), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_data(dn_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    @(negedge clk_src);
    up_valid = 1'b1;
    up_data  = w;
    while (!up_ready) @(negedge clk_src);
    @(negedge clk_src);
    up_valid = 1'b0;
    chk(up_ready == 1'b0, "R2", "up_ready after transfer", {31'd0, up_ready}, 32'd0);
  endtask

  task automatic recv_word(input logic [DW-1:0] exp, input int stall);
    int waited = 0;
    @(negedge clk_dst);
    while (!dn_valid && waited < 400) begin
      @(negedge clk_dst);
      waited++;
    end
    chk(dn_valid == 1'b1, "R3", "dn_valid arrives", {31'd0, dn_valid}, 32'd1);
    chk(dn_data == exp, "R3", "delivered word", {16'd0, dn_data}, {16'd0, exp});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk_dst);
      chk(dn_valid == 1'b1, "R5", "valid held in stall", {31'd0, dn_valid}, 32'd1);
      chk(dn_data == exp, "R5", "data held in stall", {16'd0, dn_data}, {16'd0, exp});
      chk(up_ready == 1'b0, "R6", "up_ready low while stalled", {31'd0, up_ready}, 32'd0);
    end
    dn_ready = 1'b1;
    @(negedge clk_dst);
    dn_ready = 1'b0;
    chk(dn_valid == 1'b0, "R5", "valid drops after take", {31'd0, dn_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_src);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #20;
    chk(dn_valid == 1'b0, "R1", "dn_valid in reset", {31'd0, dn_valid}, 32'd0);
    chk(up_ready == 1'b1, "R1", "up_ready in reset", {31'd0, up_ready}, 32'd1);
    @(negedge clk_src); rst_src_n = 1'b1;
    @(negedge clk_dst); rst_dst_n = 1'b1;
    repeat (20) @(negedge clk_dst);
    chk(dn_valid == 1'b0, "R1", "dn_valid idle after reset", {31'd0, dn_valid}, 32'd0);
    @(negedge clk_src);
    chk(up_ready == 1'b1, "R1", "up_ready idle after reset", {31'd0, up_ready}, 32'd1);

    // table walk: R3, R5, R6
    for (int v = 0; v < NV; v++) begin
      send_word(VEC[v][DW+3:4]);
      recv_word(VEC[v][DW+3:4], int'(VEC[v][3:0]));
    end

    // R8 / R4: valid held with a new word while the first is in flight
    @(negedge clk_src);
    up_valid = 1'b1;
    up_data  = 16'hC0DE;
    while (!up_ready) @(negedge clk_src);
    @(negedge clk_src);
    up_data = 16'hBEEF;
    chk(up_ready == 1'b0, "R8", "second word not taken", {31'd0, up_ready}, 32'd0);
    recv_word(16'hC0DE, 6);
    fork
      begin
        while (!up_ready) @(negedge clk_src);
        @(negedge clk_src);
        up_valid = 1'b0;
      end
      recv_word(16'hBEEF, 0);
    join

    // R7: quiet after full exchange, no repeat delivery
    repeat (30) @(negedge clk_dst);
    chk(dn_valid == 1'b0, "R7", "no repeat delivery", {31'd0, dn_valid}, 32'd0);
    @(negedge clk_src);
    chk(up_ready == 1'b1, "R7", "source idle after exchange", {31'd0, up_ready}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule